// File: doc/BRIEF.md
# Dual-Vector Interrupt Responder

This block is the interrupt-vector logic of a peripheral with two interrupt sources, receive and transmit, such as a terminal port. Software programs one base vector through a small register write port. When the bus acknowledges an interrupt, the block drives a 16-bit vector that is derived from that base. The vector points at the receive handler or the transmit handler. Bit 2 of the vector tells the two apart, and bits 1 and 0 are always zero.

A rising edge on either ready line latches a pending flag for that source. The request output is high while any pending source has its enable set. Each acknowledge serves one source, with receive served first, and clears that source's pending flag. The vector is driven only during the acknowledge. A one-cycle strobe marks it as valid.

Top module: `dual_vec_irq`

## Requirements
- R1: After reset, irq_o, vec_valid_o, vector_o and range_err_o are 0, the stored base is 0 and both enables are clear, so the first receive acknowledge after enabling presents vector 0.
- R2: irq_o is high exactly when at least one source is pending and its enable is set. The enables are written with wr_sel_i = 1: bit 0 enables receive and bit 1 enables transmit.
- R3: A 0-to-1 change on rx_ready_i or tx_ready_i makes that source pending from the next clock edge. The acknowledge that serves a source clears its pending flag.
- R4: When both sources are pending and enabled, the first acknowledge serves receive and the next one serves transmit.
- R5: The presented vector is {stored base bits 15..3, s, 2'b00}, where s = 0 for receive and s = 1 for transmit. Written bits 2..0 are never stored, and bits 1..0 of vector_o are always 0.
- R6: vector_o is 0 whenever iack_i is low.
- R7: A rising edge of iack_i that is sampled while irq_o is high makes vec_valid_o high for exactly the one cycle after that edge. The vector stays on vector_o while iack_i remains high.
- R8: A vector write (wr_sel_i = 0) whose value, with bits 1..0 cleared, lies outside octal 300..774 sets range_err_o and is still stored. A write inside that range clears range_err_o.
- R9: Register writes take effect while both enables are clear. A source that becomes ready while its enable is clear stays pending and raises irq_o once it is enabled.
- R10: An acknowledge while irq_o is low produces no strobe and leaves vector_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 vector base, 1 enables |
| wr_data_i | input | 16 | Write data |
| rx_ready_i | input | 1 | Receive ready request line |
| tx_ready_i | input | 1 | Transmit ready request line |
| iack_i | input | 1 | Interrupt acknowledge from the bus |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 16 | Vector, non-zero only during acknowledge |
| vec_valid_o | output | 1 | One-cycle vector valid strobe |
| range_err_o | output | 1 | Last vector write was out of range |

## Verification
The bench builds the block with its default parameters: a 16-bit vector and a legal window of octal 300 to 774. With these values, both window edges can be reached by direct writes. Octal 274 lies just below the window, octal 774 lies exactly on the top edge, and octal 1000 lies above it. Writing the top edge also shows that bit 2 is dropped from the stored base while the transmit vector sets it again.

// File: rtl/dvi_pkg.sv
package dvi_pkg;
  localparam int unsigned SEL_BIT = 2;
  localparam int unsigned NSRC    = 2;

  typedef enum logic {
    SRC_RX = 1'b0,
    SRC_TX = 1'b1
  } src_e;

  typedef enum logic [1:0] {
    REG_VEC = 2'd0,
    REG_CTL = 2'd1
  } reg_sel_e;
endpackage

// File: rtl/dvi_vec_reg.sv
module dvi_vec_reg
  import dvi_pkg::*;
#(
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned LEGAL_LO = 'o300,
  parameter int unsigned LEGAL_HI = 'o774
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [1:0]               wr_sel_i,
  input  logic [VEC_W-1:0]         wr_data_i,
  output logic [VEC_W-1:SEL_BIT+1] base_o,
  output logic [NSRC-1:0]          ie_o,
  output logic                     err_o
);
  localparam logic [VEC_W-1:0] LO_V = VEC_W'(LEGAL_LO);
  localparam logic [VEC_W-1:0] HI_V = VEC_W'(LEGAL_HI);

  logic [VEC_W-1:0] masked;
  logic             in_range;

  assign masked   = {wr_data_i[VEC_W-1:2], 2'b00};
  assign in_range = (masked >= LO_V) && (masked <= HI_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      ie_o   <= '0;
      err_o  <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_sel_i == REG_VEC) begin
        // bit 2 and below are never stored; bit 2 comes from the served source
        base_o <= wr_data_i[VEC_W-1:SEL_BIT+1];
        err_o  <= ~in_range;
      end else if (wr_sel_i == REG_CTL) begin
        ie_o <= wr_data_i[NSRC-1:0];
      end
    end
  end
endmodule

// File: rtl/dvi_src_track.sv
module dvi_src_track
  import dvi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] ready_i,
  input  logic [NSRC-1:0] ie_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] req_o
);
  logic [NSRC-1:0] ready_q;
  logic [NSRC-1:0] pend_q;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ready_q[s] <= 1'b0;
        pend_q[s]  <= 1'b0;
      end else begin
        ready_q[s] <= ready_i[s];
        // a new edge wins over a same-cycle clear
        if (ready_i[s] && !ready_q[s]) pend_q[s] <= 1'b1;
        else if (clr_i[s])             pend_q[s] <= 1'b0;
      end
    end
    assign req_o[s] = pend_q[s] & ie_i[s];
  end
endmodule

// File: rtl/dvi_ack_ctl.sv
module dvi_ack_ctl
  import dvi_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            iack_i,
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] clr_o,
  output src_e            sel_o,
  output logic            active_o,
  output logic            valid_o
);
  logic iack_q;
  logic grant;
  src_e pick;

  assign grant = iack_i & ~iack_q & (|req_i);
  assign pick  = req_i[SRC_RX] ? SRC_RX : SRC_TX;

  always_comb begin
    clr_o = '0;
    if (grant) clr_o[pick] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iack_q   <= 1'b0;
      sel_o    <= SRC_RX;
      active_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      iack_q  <= iack_i;
      valid_o <= grant;
      if (grant) begin
        sel_o    <= pick;
        active_o <= 1'b1;
      end else if (!iack_i) begin
        active_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_vec_irq.sv
module dual_vec_irq
  import dvi_pkg::*;
#(
  parameter int unsigned VEC_W    = 16,
  parameter int unsigned LEGAL_LO = 'o300,
  parameter int unsigned LEGAL_HI = 'o774
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [VEC_W-1:0] wr_data_i,
  input  logic             rx_ready_i,
  input  logic             tx_ready_i,
  input  logic             iack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vector_o,
  output logic             vec_valid_o,
  output logic             range_err_o
);
  logic [VEC_W-1:SEL_BIT+1] base;
  logic [NSRC-1:0]          ie;
  logic [NSRC-1:0]          req;
  logic [NSRC-1:0]          clr;
  src_e                     sel;
  logic                     active;

  dvi_vec_reg #(
    .VEC_W(VEC_W), .LEGAL_LO(LEGAL_LO), .LEGAL_HI(LEGAL_HI)
  ) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .base_o(base), .ie_o(ie), .err_o(range_err_o)
  );

  dvi_src_track u_src (
    .clk_i, .rst_ni,
    .ready_i({tx_ready_i, rx_ready_i}),
    .ie_i(ie), .clr_i(clr), .req_o(req)
  );

  dvi_ack_ctl u_ack (
    .clk_i, .rst_ni, .iack_i, .req_i(req),
    .clr_o(clr), .sel_o(sel), .active_o(active), .valid_o(vec_valid_o)
  );

  assign irq_o    = |req;
  assign vector_o = (iack_i && active) ? {base, sel, 2'b00} : '0;
endmodule

// File: rtl/dvi_irq_checker.sv
module dvi_irq_checker #(
  parameter int unsigned VEC_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             iack_i,
  input logic             irq_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             vec_valid_o
);
  p_low_bits_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_o[1:0] == 2'b00);

  p_idle_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iack_i |-> vector_o == '0);

  p_single_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |=> !vec_valid_o);

  p_strobe_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(iack_i));

  p_strobe_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(irq_o));
endmodule

bind dual_vec_irq dvi_irq_checker #(.VEC_W(VEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .iack_i(iack_i), .irq_o(irq_o),
  .vector_o(vector_o), .vec_valid_o(vec_valid_o)
);

// File: tb/dual_vec_irq_test.sv
module dual_vec_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        rx_rdy = 1'b0;
  logic        tx_rdy = 1'b0;
  logic        iack = 1'b0;
  logic        irq;
  logic [15:0] vec;
  logic        vld;
  logic        err;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dual_vec_irq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rx_ready_i(rx_rdy), .tx_ready_i(tx_rdy),
    .iack_i(iack), .irq_o(irq), .vector_o(vec), .vec_valid_o(vld),
    .range_err_o(err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input bit rx, input bit tx);
    @(negedge clk);
    rx_rdy = rx; tx_rdy = tx;
    @(negedge clk);
    rx_rdy = 1'b0; tx_rdy = 1'b0;
  endtask

  // acknowledge held for two cycles, strobe and vector checked
  task automatic ack(input string req, input logic [15:0] exp);
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk);
    chk({req, " strobe"}, 16'(vld), 16'd1);
    chk({req, " vector"}, vec, exp);
    @(negedge clk);
    chk("R7 strobe one cycle", 16'(vld), 16'd0);
    chk("R7 vector held", vec, exp);
    iack = 1'b0;
    #1 chk("R6 vector idle", vec, 16'd0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 valid", 16'(vld), 16'd0);
    chk("R1 vector", vec, 16'd0);
    chk("R1 err", 16'(err), 16'd0);
    pulse(1'b1, 1'b0);
    chk("R1 enables clear", 16'(irq), 16'd0);
    wr(2'd1, 16'h0001);
    chk("R9 irq after enable", 16'(irq), 16'd1);
    ack("R1 zero base", 16'h0000);
    chk("R3 cleared", 16'(irq), 16'd0);
  endtask

  task automatic t_format;
    wr(2'd0, 16'h00C7);
    chk("R8 in range", 16'(err), 16'd0);
    wr(2'd1, 16'h0003);
    pulse(1'b1, 1'b0);
    chk("R2 rx irq", 16'(irq), 16'd1);
    ack("R5 rx vector", 16'h00C0);
    pulse(1'b0, 1'b1);
    ack("R5 tx vector", 16'h00C4);
    chk("R3 cleared tx", 16'(irq), 16'd0);
  endtask

  task automatic t_both;
    pulse(1'b1, 1'b1);
    chk("R2 both", 16'(irq), 16'd1);
    ack("R4 rx first", 16'h00C0);
    chk("R4 tx still pending", 16'(irq), 16'd1);
    ack("R4 tx second", 16'h00C4);
    chk("R3 none left", 16'(irq), 16'd0);
  endtask

  task automatic t_disabled;
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0140);
    pulse(1'b0, 1'b1);
    chk("R2 tx masked", 16'(irq), 16'd0);
    wr(2'd1, 16'h0001);
    chk("R2 rx enable only", 16'(irq), 16'd0);
    wr(2'd1, 16'h0002);
    chk("R9 tx raised", 16'(irq), 16'd1);
    ack("R9 tx vector", 16'h0144);
  endtask

  task automatic t_range;
    wr(2'd1, 16'h0001);
    wr(2'd0, 16'h0200);
    chk("R8 above", 16'(err), 16'd1);
    pulse(1'b1, 1'b0);
    ack("R8 stored anyway", 16'h0200);
    wr(2'd0, 16'h00BC);
    chk("R8 below", 16'(err), 16'd1);
    wr(2'd0, 16'h01FF);
    chk("R8 top edge", 16'(err), 16'd0);
    pulse(1'b1, 1'b0);
    ack("R5 top edge rx", 16'h01F8);
  endtask

  task automatic t_no_req;
    chk("R10 idle irq", 16'(irq), 16'd0);
    @(negedge clk);
    iack = 1'b1;
    @(negedge clk);
    chk("R10 no strobe", 16'(vld), 16'd0);
    chk("R10 vector zero", vec, 16'd0);
    @(negedge clk);
    chk("R10 no strobe late", 16'(vld), 16'd0);
    iack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_format();
    t_both();
    t_disabled();
    t_range();
    t_no_req();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule